// File: doc/BRIEF.md
# Timer-Paced Double-Buffered Dual DAC Streamer

This block plays out batches of 16-bit codes to two DACs, each attached through its own write-only SPI link. The processor does no work per sample. A free-running sample timer counts from zero up to a programmable period. At two fixed compare counts, one tick apart, it releases one update request for channel 0 and then one for channel 1. Each request reads the next code from the active half of a per-channel ping-pong buffer. The serializer for that channel then shifts the code out with chip select held low.

After the last entry of a batch has been released on both channels, the two halves trade roles. The block raises a one-cycle batch-complete pulse and a sticky refill flag, and reports which half is now idle. The host fills the idle half through a simple write port and has one batch period in which to do so. The swap happens on schedule whether or not the refill arrived, so a late host makes the old codes play again. Batch timing never stretches, which keeps the host's fixed three-batch input-to-output latency constant. To turn several input samples into one output value, the host writes the same code into several slots, so a batch always holds one code per input sample.

Top module: `dac_stream_top`

## Requirements
- R1: During and after reset, both chip selects are high (1), both serial clocks and data lines are low, `batch_done_o` and `refill_flag_o` are low, and `idle_half_o` is 1 (half 0 is active first).
- R2: When `period_i` is nonzero, the timer counts 0 to `period_i`-1 and wraps, so successive frames on a channel start `period_i` clock cycles apart. A period of 0 holds the timer and starts no frames. Channel 0's request fires at count 2 and channel 1's at count 3, so channel 1's chip select falls exactly one clock after channel 0's.
- R3: Each request produces exactly one frame. Chip select stays low for 16 bits, the code is sent MSB first, and the serial clock idles low. Data changes after a falling edge and is valid at each rising edge. Each bit lasts 2*`SCLK_DIV` clocks.
- R4: Within a batch, both channels send entries 0 to `BATCH_LEN`-1 of the active half in index order, and they use the same index in a given timer period.
- R5: The halves swap after channel 1's request for the last index. `batch_done_o` is then high for exactly one cycle. At a constant period, pulses are `BATCH_LEN`*`period_i` cycles apart.
- R6: A host write (`wr_en_i`, channel `wr_ch_i`, index `wr_idx_i`, data `wr_data_i`) stores into the idle half only. The codes that the active half is sending are unaffected.
- R7: The swap is unconditional. A half that has not been rewritten sends its previous contents again.
- R8: Each swap sets `refill_flag_o`, and `idle_half_o` names the idle half. The flag clears on a host write to index `BATCH_LEN`-1 of either channel. Writes to other indices leave it set.
- R9: A request that arrives while its channel's frame is still in progress is held and sent as soon as that frame ends. Chip select is high for one cycle between the two frames, and the codes keep their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | TIMER_W | Sample period in clocks; 0 stops the timer |
| wr_en_i | input | 1 | Host write strobe |
| wr_ch_i | input | 1 | Channel selected by the host write |
| wr_idx_i | input | IDX_W | Entry index within the idle half |
| wr_data_i | input | CODE_W | Code to store |
| batch_done_o | output | 1 | One-cycle pulse at each half swap |
| refill_flag_o | output | 1 | Sticky: idle half awaits refill |
| idle_half_o | output | 1 | Index of the half the host may write |
| dac_cs_n_o | output | 2 | Per-channel chip select, active low |
| dac_sclk_o | output | 2 | Per-channel serial clock |
| dac_mosi_o | output | 2 | Per-channel serial data |

## Verification
The assertions assume that `period_i` stays above the channel 1 compare count whenever it is nonzero. They also assume it is never so short that a channel receives a second request while one is already held. The stimulus runs mostly at a period longer than a frame. It drops below the frame length for just one batch, which forces held requests without exceeding the one-deep hold. The host writes only right after a swap, well away from the next one. The period is changed only at batch boundaries, so the staggered pair of requests is never split.

// File: rtl/dstr_pkg.sv
package dstr_pkg;
  localparam int NCH = 2;
  localparam int CH_W = 1;

  typedef enum logic {
    TX_IDLE,
    TX_SHIFT
  } tx_state_e;
endpackage

// File: rtl/dstr_timer.sv
module dstr_timer #(
  parameter int TIMER_W = 16,
  parameter int CMP0    = 2,
  parameter int CMP1    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TIMER_W-1:0] period_i,
  output logic [1:0]         ev_o
);
  logic [TIMER_W-1:0] count_q;
  logic [1:0]         ev_q;
  logic               run;

  assign run = (period_i != '0);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      count_q <= '0;
    end else if (count_q >= period_i - 1'b1) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q <= '0;
    end else begin
      ev_q[0] <= run && (count_q == TIMER_W'(CMP0));
      ev_q[1] <= run && (count_q == TIMER_W'(CMP1));
    end
  end

  assign ev_o = ev_q;

  // R2
  count_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (period_i != '0 && count_q >= period_i - 1'b1) |=> (count_q == '0));

  // R2
  stagger_chk: assert property (@(posedge clk) disable iff (rst)
    ev_q[1] |-> $past(ev_q[0]));
endmodule

// File: rtl/dstr_pingpong.sv
module dstr_pingpong
  import dstr_pkg::*;
#(
  parameter int CODE_W    = 16,
  parameter int BATCH_LEN = 4,
  parameter int IDX_W     = (BATCH_LEN > 1) ? $clog2(BATCH_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    ev_i,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [CODE_W-1:0] wr_data_i,
  output logic [NCH-1:0]    start_o,
  output logic [CODE_W-1:0] code_o [NCH],
  output logic              done_o,
  output logic              flag_o,
  output logic              idle_o
);
  localparam int DEPTH = 2 * (1 << IDX_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BATCH_LEN - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             flag_q;
  logic [NCH-1:0]   start_q;
  logic             wr_ok;
  logic             swap;

  assign wr_ok = wr_en_i && (wr_idx_i <= LAST);
  assign swap  = ev_i[NCH-1] && (idx_q == LAST);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CODE_W-1:0] mem [0:DEPTH-1];
    logic [CODE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_ok && wr_ch_i == CH_W'(g)) begin
        mem[{~active_q, wr_idx_i}] <= wr_data_i;
      end
      if (ev_i[g]) begin
        rd_q <= mem[{active_q, idx_q}];
      end
    end

    assign code_o[g] = rd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      done_q   <= 1'b0;
      flag_q   <= 1'b0;
      start_q  <= '0;
    end else begin
      start_q <= ev_i;
      done_q  <= swap;
      if (ev_i[NCH-1]) begin
        if (swap) begin
          idx_q    <= '0;
          active_q <= ~active_q;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
      if (swap) begin
        flag_q <= 1'b1;
      end else if (wr_en_i && wr_idx_i == LAST) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign start_o = start_q;
  assign done_o  = done_q;
  assign flag_o  = flag_q;
  assign idle_o  = ~active_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R5
  swap_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (active_q != $past(active_q)));

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> flag_q);
endmodule

// File: rtl/dstr_spi_tx.sv
module dstr_spi_tx
  import dstr_pkg::*;
#(
  parameter int CODE_W   = 16,
  parameter int SCLK_DIV = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CODE_W-1:0] data_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              mosi_o
);
  localparam int DIV_W = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;
  localparam int BIT_W = $clog2(CODE_W);

  tx_state_e         st_q;
  logic              cs_n_q;
  logic              sclk_q;
  logic [CODE_W-1:0] sh_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DIV_W-1:0]  div_q;
  logic              pend_q;
  logic [CODE_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= TX_IDLE;
      cs_n_q <= 1'b1;
      sclk_q <= 1'b0;
      sh_q   <= '0;
      bit_q  <= '0;
      div_q  <= '0;
      pend_q <= 1'b0;
      hold_q <= '0;
    end else begin
      case (st_q)
        TX_IDLE: begin
          if (pend_q) begin
            sh_q   <= hold_q;
            cs_n_q <= 1'b0;
            st_q   <= TX_SHIFT;
            bit_q  <= '0;
            div_q  <= '0;
            if (start_i) begin
              hold_q <= data_i;
            end else begin
              pend_q <= 1'b0;
            end
          end else if (start_i) begin
            sh_q   <= data_i;
            cs_n_q <= 1'b0;
            st_q   <= TX_SHIFT;
            bit_q  <= '0;
            div_q  <= '0;
          end
        end
        default: begin
          if (start_i) begin
            pend_q <= 1'b1;
            hold_q <= data_i;
          end
          if (div_q == DIV_W'(SCLK_DIV - 1)) begin
            div_q  <= '0;
            sclk_q <= ~sclk_q;
            if (sclk_q) begin
              if (bit_q == BIT_W'(CODE_W - 1)) begin
                cs_n_q <= 1'b1;
                st_q   <= TX_IDLE;
                sh_q   <= '0;
              end else begin
                bit_q <= bit_q + 1'b1;
                sh_q  <= {sh_q[CODE_W-2:0], 1'b0};
              end
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign cs_n_o = cs_n_q;
  assign sclk_o = sclk_q;
  assign mosi_o = sh_q[CODE_W-1];

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_q |-> !sclk_q);

  // R9
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && pend_q) |-> (st_q == TX_IDLE));

  // R3
  frame_open_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_q) |-> (!sclk_q && $past(st_q) == TX_IDLE));
endmodule

// File: rtl/dac_stream_top.sv
module dac_stream_top
  import dstr_pkg::*;
#(
  parameter int CODE_W    = 16,
  parameter int BATCH_LEN = 4,
  parameter int TIMER_W   = 16,
  parameter int CMP0      = 2,
  parameter int CMP1      = 3,
  parameter int SCLK_DIV  = 1,
  parameter int IDX_W     = (BATCH_LEN > 1) ? $clog2(BATCH_LEN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TIMER_W-1:0] period_i,
  input  logic               wr_en_i,
  input  logic               wr_ch_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [CODE_W-1:0]  wr_data_i,
  output logic               batch_done_o,
  output logic               refill_flag_o,
  output logic               idle_half_o,
  output logic [1:0]         dac_cs_n_o,
  output logic [1:0]         dac_sclk_o,
  output logic [1:0]         dac_mosi_o
);
  logic [NCH-1:0]    ev;
  logic [NCH-1:0]    start;
  logic [CODE_W-1:0] code [NCH];

  dstr_timer #(
    .TIMER_W (TIMER_W),
    .CMP0    (CMP0),
    .CMP1    (CMP1)
  ) timer_i (
    .clk      (clk),
    .rst      (rst),
    .period_i (period_i),
    .ev_o     (ev)
  );

  dstr_pingpong #(
    .CODE_W    (CODE_W),
    .BATCH_LEN (BATCH_LEN),
    .IDX_W     (IDX_W)
  ) buf_i (
    .clk       (clk),
    .rst       (rst),
    .ev_i      (ev),
    .wr_en_i   (wr_en_i),
    .wr_ch_i   (wr_ch_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .start_o   (start),
    .code_o    (code),
    .done_o    (batch_done_o),
    .flag_o    (refill_flag_o),
    .idle_o    (idle_half_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_tx
    dstr_spi_tx #(
      .CODE_W   (CODE_W),
      .SCLK_DIV (SCLK_DIV)
    ) tx_i (
      .clk     (clk),
      .rst     (rst),
      .start_i (start[g]),
      .data_i  (code[g]),
      .cs_n_o  (dac_cs_n_o[g]),
      .sclk_o  (dac_sclk_o[g]),
      .mosi_o  (dac_mosi_o[g])
    );
  end
endmodule

// File: tb/dac_stream_top_tb_top.sv
`timescale 1ns/1ps
module dac_stream_top_tb_top;
  localparam int L = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] period_i = '0;
  logic        wr_en_i = 1'b0;
  logic        wr_ch_i = 1'b0;
  logic [1:0]  wr_idx_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        batch_done_o, refill_flag_o, idle_half_o;
  logic [1:0]  dac_cs_n_o, dac_sclk_o, dac_mosi_o;

  int vecs = 0;
  int errs = 0;
  int cyc  = 0;

  logic [15:0] rx [2][64];
  int          ts [2][64];
  int          nrx [2];
  int          nbit [2];
  logic [15:0] sr [2];
  logic [1:0]  pcs = 2'b11;
  logic [1:0]  psck = 2'b00;
  int          dtime [16];
  int          nd = 0;

  dac_stream_top dut_i (
    .clk (clk), .rst (rst), .period_i (period_i),
    .wr_en_i (wr_en_i), .wr_ch_i (wr_ch_i), .wr_idx_i (wr_idx_i),
    .wr_data_i (wr_data_i), .batch_done_o (batch_done_o),
    .refill_flag_o (refill_flag_o), .idle_half_o (idle_half_o),
    .dac_cs_n_o (dac_cs_n_o), .dac_sclk_o (dac_sclk_o),
    .dac_mosi_o (dac_mosi_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Serial decoder, sampled away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      nrx[0] = 0; nrx[1] = 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (pcs[c] && !dac_cs_n_o[c]) begin
          ts[c][nrx[c]] = cyc;
          sr[c] = '0;
          nbit[c] = 0;
        end
        if (!dac_cs_n_o[c] && dac_sclk_o[c] && !psck[c]) begin
          sr[c] = {sr[c][14:0], dac_mosi_o[c]};
          nbit[c]++;
        end
        if (!pcs[c] && dac_cs_n_o[c]) begin
          vecs++;
          if (nbit[c] != 16) begin
            errs++;
            $display("FAIL R3 ch%0d frame bits actual=%0d expected=16", c, nbit[c]);
          end
          rx[c][nrx[c]] = sr[c];
          nrx[c]++;
        end
      end
      pcs = dac_cs_n_o;
      psck = dac_sclk_o;
      if (batch_done_o) begin
        dtime[nd] = cyc;
        nd++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] code_of(input logic [7:0] tag, input int ch, input int i);
    return {tag, ch[3:0], i[3:0]};
  endfunction

  task automatic host_wr(input int ch, input int idx, input logic [15:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_ch_i = ch[0]; wr_idx_i = idx[1:0]; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_done(input int k);
    while (nd < k) @(negedge clk);
    // R5: pulse lasts one cycle
    @(negedge clk);
    check(batch_done_o == 1'b0, "R5 done pulse width", batch_done_o, 0);
  endtask

  // Fill the idle half; R8 flag held until the last index is written
  task automatic fill(input logic [7:0] tag);
    for (int i = 0; i < L; i++) begin
      host_wr(0, i, code_of(tag, 0, i));
      if (i < L - 1)
        check(refill_flag_o == 1'b1, "R8 flag kept by non-last write", refill_flag_o, 1);
      else
        check(refill_flag_o == 1'b0, "R8 flag cleared by last index", refill_flag_o, 0);
    end
    for (int i = 0; i < L; i++) host_wr(1, i, code_of(tag, 1, i));
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    // R1
    check(dac_cs_n_o == 2'b11, "R1 cs idle", dac_cs_n_o, 3);
    check(dac_sclk_o == 2'b00 && dac_mosi_o == 2'b00, "R1 sclk/mosi low",
          {dac_sclk_o, dac_mosi_o}, 0);
    check(!batch_done_o && !refill_flag_o, "R1 done/flag low",
          {batch_done_o, refill_flag_o}, 0);
    check(idle_half_o == 1'b1, "R1 idle half", idle_half_o, 1);
    rst = 1'b0;
    repeat (50) @(negedge clk);
    // R2: period 0 holds the timer
    check(nrx[0] == 0 && dac_cs_n_o == 2'b11, "R2 stopped timer", nrx[0], 0);
  endtask

  task automatic t_stream;
    period_i = 16'd40;
    wait_done(1);
    check(refill_flag_o && idle_half_o == 1'b0, "R8 flag/idle after swap 1",
          {refill_flag_o, idle_half_o}, 2);
    fill(8'hA1);                       // half 0
    wait_done(2);
    check(idle_half_o == 1'b1, "R8 idle half after swap 2", idle_half_o, 1);
    fill(8'hB2);                       // half 1
    wait_done(3);                      // no refill of half 0: R7
    check(dtime[2] - dtime[1] == L * 40, "R5 batch interval", dtime[2] - dtime[1], L * 40);
    wait_done(4);
    fill(8'hC3);                       // half 1 while A replays: R6
    wait_done(5);
    period_i = 16'd30;                 // shorter than a frame: R9
    wait_done(6);
    period_i = 16'd0;
    repeat (300) @(negedge clk);
  endtask

  task automatic t_results;
    logic [7:0] tags [4];
    tags[0] = 8'hA1; tags[1] = 8'hB2; tags[2] = 8'hA1; tags[3] = 8'hC3;
    // R3: one frame per request, six batches
    check(nrx[0] == 6 * L, "R3 frame count ch0", nrx[0], 6 * L);
    check(nrx[1] == 6 * L, "R3 frame count ch1", nrx[1], 6 * L);
    // R4 order, R6 isolation, R7 stale replay
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < L; i++)
          check(rx[c][(b + 2) * L + i] == code_of(tags[b], c, i),
                (b == 2) ? "R7 stale replay" : "R4 code order",
                rx[c][(b + 2) * L + i], code_of(tags[b], c, i));
    // R2 stagger and spacing
    for (int k = 2 * L; k < 3 * L; k++)
      check(ts[1][k] - ts[0][k] == 1, "R2 stagger", ts[1][k] - ts[0][k], 1);
    check(ts[0][2 * L + 1] - ts[0][2 * L] == 40, "R2 frame spacing",
          ts[0][2 * L + 1] - ts[0][2 * L], 40);
    // R9: held request starts one idle cycle after the previous frame
    check(ts[0][5 * L + 2] - ts[0][5 * L + 1] == 33, "R9 held frame start",
          ts[0][5 * L + 2] - ts[0][5 * L + 1], 33);
    check(ts[1][5 * L + 2] - ts[0][5 * L + 2] == 1, "R9 stagger kept when held",
          ts[1][5 * L + 2] - ts[0][5 * L + 2], 1);
  endtask

  initial begin
    t_reset;
    t_stream;
    t_results;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule